// File: doc/BRIEF.md
# Carry-Chained Add/Subtract Flag Unit

This block is the arithmetic slice of a small 8-bit integer datapath. It adds with carry, or subtracts with borrow, an accumulator operand and a second operand taken from memory or an immediate field. The carry-in is the C bit of the condition-code byte supplied with the operands. The unit drives the 8-bit result and the next condition-code byte straight away from its inputs. It also holds a registered copy of both, which is loaded on one clock edge when the update strobe is high.

The half-carry flag is bit 4 of the result XORed with both raw operands, and only the add operation writes it. The subtract operation keeps the incoming half-carry. Overflow and half-carry always see the operand as presented: the carry-in changes only the arithmetic result and the carry-out. Bits of the condition-code byte that hold no arithmetic flag pass through unchanged.

Top module: `cc_addsub_unit`

## Requirements
- R1: With op_sub=0, sum_out is the low 8 bits of acc_in + opnd_in + cin, where cin is bit 0 of cc_in. Bit 0 of cc_next is bit 8 of that 9-bit sum.
- R2: With op_sub=1, sum_out is the low 8 bits of acc_in - opnd_in - cin at 9 bits. Bit 0 of cc_next is bit 8 of that difference (the borrow).
- R3: With op_sub=0, bit 5 of cc_next (half-carry) is bit 4 of sum_out ^ opnd_in ^ acc_in, computed on the raw operands. This equals the carry out of the low nibble, carry-in included.
- R4: With op_sub=0, bit 1 of cc_next (overflow) is bit 7 of (sum_out ^ opnd_in) & (sum_out ^ acc_in).
- R5: With op_sub=1, bit 1 of cc_next is bit 7 of (acc_in ^ opnd_in) & (acc_in ^ sum_out).
- R6: For both operations, bit 3 of cc_next is bit 7 of sum_out. Bit 2 of cc_next is 1 exactly when sum_out is zero.
- R7: With op_sub=1, bit 5 of cc_next equals bit 5 of cc_in.
- R8: Bits 7, 6 and 4 of cc_next equal the same bits of cc_in.
- R9: On a rising clock edge with upd_en=1, sum_q and cc_q both load sum_out and cc_next. With upd_en=0, both hold their values.
- R10: A synchronous reset (rst=1 at a rising edge) clears sum_q and cc_q to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| upd_en | input | 1 | Load the result and flag registers on this edge |
| op_sub | input | 1 | 0 = add with carry, 1 = subtract with borrow |
| acc_in | input | 8 | Accumulator operand |
| opnd_in | input | 8 | Memory or immediate operand |
| cc_in | input | 8 | Current condition-code byte; bit 0 is the carry-in |
| sum_out | output | 8 | Combinational result |
| cc_next | output | 8 | Combinational next condition-code byte |
| sum_q | output | 8 | Registered result |
| cc_q | output | 8 | Registered condition-code byte |

## Verification
The bench builds the unit with its default 8-bit data width. At that width the full operand space is small enough to sweep. Every accumulator and operand pair is applied with both carry-in values and both operations, and random values fill the unused condition-code bits. A random run with directed edge values then checks that the registers load, hold and reset. The expected flags come from signed-overflow and nibble-carry arithmetic rather than from the XOR forms used in the design.

// File: rtl/cc_pkg.sv
package cc_pkg;

    typedef enum logic {
        OP_ADD_C = 1'b0,
        OP_SUB_B = 1'b1
    } op_e;

    typedef struct packed {
        logic half;
        logic neg;
        logic zero;
        logic ovf;
        logic carry;
    } flags_t;

endpackage

// File: rtl/cc_arith.sv
module cc_arith #(
    parameter int W = 8
) (
    input  logic           sub_i,
    input  logic           cin_i,
    input  logic [W-1:0]   a_i,
    input  logic [W-1:0]   b_i,
    output logic [W:0]     wide_o
);
    logic [W:0] a_ext;
    logic [W:0] b_ext;
    logic [W:0] c_ext;

    always_comb begin
        a_ext = {1'b0, a_i};
        b_ext = {1'b0, b_i};
        c_ext = {{W{1'b0}}, cin_i};
        if (sub_i) begin
            wide_o = a_ext - b_ext - c_ext;
        end else begin
            wide_o = a_ext + b_ext + c_ext;
        end
    end

endmodule

// File: rtl/cc_flag_gen.sv
module cc_flag_gen
    import cc_pkg::*;
#(
    parameter int W = 8
) (
    input  logic           sub_i,
    input  logic           h_prev_i,
    input  logic [W-1:0]   a_i,
    input  logic [W-1:0]   b_i,
    input  logic [W:0]     wide_i,
    output flags_t         flags_o
);
    localparam int MSB   = W - 1;
    localparam int HBIT  = W / 2;

    logic [W-1:0] res;
    logic [W-1:0] xor3;
    logic [W-1:0] ovf_vec;

    always_comb begin
        res  = wide_i[W-1:0];
        xor3 = res ^ a_i ^ b_i;
        if (sub_i) begin
            ovf_vec = (a_i ^ b_i) & (a_i ^ res);
        end else begin
            ovf_vec = (res ^ b_i) & (res ^ a_i);
        end
        flags_o.half  = sub_i ? h_prev_i : xor3[HBIT];
        flags_o.neg   = res[MSB];
        flags_o.zero  = (res == '0);
        flags_o.ovf   = ovf_vec[MSB];
        flags_o.carry = wide_i[W];
    end

endmodule

// File: rtl/cc_addsub_unit.sv
module cc_addsub_unit
    import cc_pkg::*;
#(
    parameter int W      = 8,
    parameter int CC_W   = 8,
    parameter int H_POS  = 5,
    parameter int N_POS  = 3,
    parameter int Z_POS  = 2,
    parameter int V_POS  = 1,
    parameter int C_POS  = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              upd_en,
    input  logic              op_sub,
    input  logic [W-1:0]      acc_in,
    input  logic [W-1:0]      opnd_in,
    input  logic [CC_W-1:0]   cc_in,
    output logic [W-1:0]      sum_out,
    output logic [CC_W-1:0]   cc_next,
    output logic [W-1:0]      sum_q,
    output logic [CC_W-1:0]   cc_q
);
    localparam logic [CC_W-1:0] FLAG_MASK =
        (CC_W'(1) << H_POS) | (CC_W'(1) << N_POS) | (CC_W'(1) << Z_POS) |
        (CC_W'(1) << V_POS) | (CC_W'(1) << C_POS);
    localparam logic [CC_W-1:0] KEEP_MASK = ~FLAG_MASK;

    typedef struct packed {
        logic [W-1:0]    sum;
        logic [CC_W-1:0] cc;
    } unit_state_t;

    op_e          op;
    logic [W:0]   wide;
    flags_t       flg;
    unit_state_t  state_d;
    unit_state_t  state_q;

    assign op = op_e'(op_sub);

    cc_arith #(.W(W)) u_arith (
        .sub_i  (op == OP_SUB_B),
        .cin_i  (cc_in[C_POS]),
        .a_i    (acc_in),
        .b_i    (opnd_in),
        .wide_o (wide)
    );

    cc_flag_gen #(.W(W)) u_flags (
        .sub_i    (op == OP_SUB_B),
        .h_prev_i (cc_in[H_POS]),
        .a_i      (acc_in),
        .b_i      (opnd_in),
        .wide_i   (wide),
        .flags_o  (flg)
    );

    always_comb begin
        state_d        = state_q;
        sum_out        = wide[W-1:0];
        cc_next        = cc_in & KEEP_MASK;
        cc_next[H_POS] = flg.half;
        cc_next[N_POS] = flg.neg;
        cc_next[Z_POS] = flg.zero;
        cc_next[V_POS] = flg.ovf;
        cc_next[C_POS] = flg.carry;
        if (upd_en) begin
            state_d.sum = sum_out;
            state_d.cc  = cc_next;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign sum_q = state_q.sum;
    assign cc_q  = state_q.cc;

    assert_reset_clears_R10: assert property (@(posedge clk)
        rst |=> (sum_q == '0) && (cc_q == '0));

    assert_hold_idle_R9: assert property (@(posedge clk) disable iff (rst)
        !upd_en |=> $stable(sum_q) && $stable(cc_q));

    assert_sign_zero_R6: assert property (@(posedge clk) disable iff (rst)
        upd_en |=> (cc_q[N_POS] == sum_q[W-1]) && (cc_q[Z_POS] == (sum_q == '0)));

    assert_sub_keeps_half_R7: assert property (@(posedge clk) disable iff (rst)
        (upd_en && op_sub) |=> cc_q[H_POS] == $past(cc_in[H_POS]));

    assert_passthrough_R8: assert property (@(posedge clk) disable iff (rst)
        upd_en |=> (cc_q & KEEP_MASK) == ($past(cc_in) & KEEP_MASK));

    assert_add_carry_R1: assert property (@(posedge clk) disable iff (rst)
        (upd_en && !op_sub) |=>
            {cc_q[C_POS], sum_q} == ({1'b0, $past(acc_in)} + {1'b0, $past(opnd_in)}
                                     + {{W{1'b0}}, $past(cc_in[C_POS])}));

endmodule

// File: tb/cc_addsub_unit_bench.sv
module cc_addsub_unit_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       upd_en = 1'b0;
    logic       op_sub = 1'b0;
    logic [7:0] acc_in = '0;
    logic [7:0] opnd_in = '0;
    logic [7:0] cc_in = '0;
    logic [7:0] sum_out, cc_next, sum_q, cc_q;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    cc_addsub_unit u_cc_addsub_unit (
        .clk(clk), .rst(rst), .upd_en(upd_en), .op_sub(op_sub),
        .acc_in(acc_in), .opnd_in(opnd_in), .cc_in(cc_in),
        .sum_out(sum_out), .cc_next(cc_next), .sum_q(sum_q), .cc_q(cc_q)
    );

    function automatic logic [15:0] ref_model(input logic [7:0] a, input logic [7:0] b,
                                              input logic [7:0] cc, input logic sub);
        int ci;
        int r;
        logic [7:0] s;
        logic [7:0] o;
        logic h;
        logic v;
        ci = int'(cc[0]);
        if (!sub) begin
            r = int'(a) + int'(b) + ci;
            h = ((int'(a & 8'h0F) + int'(b & 8'h0F) + ci) > 15);
        end else begin
            r = int'(a) - int'(b) - ci;
            h = cc[5];
        end
        s = r[7:0];
        if (sub) v = (a[7] != b[7]) && (s[7] != a[7]);
        else     v = (a[7] == b[7]) && (s[7] != a[7]);
        o = cc;
        o[5] = h;
        o[3] = s[7];
        o[2] = (s == 8'h00);
        o[1] = v;
        o[0] = r[8];
        return {s, o};
    endfunction

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h (a=%02h b=%02h cc=%02h sub=%0b)",
                     tag, act, exp, acc_in, opnd_in, cc_in, op_sub);
        end
    endtask

    task automatic check_comb();
        logic [15:0] e;
        e = ref_model(acc_in, opnd_in, cc_in, op_sub);
        check(sum_out, e[15:8], op_sub ? "R2 result" : "R1 result");
        check({7'd0, cc_next[0]}, {7'd0, e[0]}, op_sub ? "R2 borrow" : "R1 carry");
        check({7'd0, cc_next[5]}, {7'd0, e[5]}, op_sub ? "R7 half kept" : "R3 half carry");
        check({7'd0, cc_next[1]}, {7'd0, e[1]}, op_sub ? "R5 overflow" : "R4 overflow");
        check({6'd0, cc_next[3:2]}, {6'd0, e[3:2]}, "R6 sign/zero");
        check(cc_next & 8'hD0, e[7:0] & 8'hD0, "R8 passthrough");
    endtask

    initial begin
        for (int i = 0; i < 150000; i++) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] exp_sum;
        logic [7:0] exp_cc;
        logic [15:0] e;
        void'($urandom(32'd1729));

        // R10: reset state
        @(negedge clk);
        @(negedge clk);
        check(sum_q, 8'h00, "R10 reset sum");
        check(cc_q, 8'h00, "R10 reset cc");

        // directed corners
        rst = 1'b0;
        op_sub = 1'b0; acc_in = 8'hFF; opnd_in = 8'h00; cc_in = 8'h01; #1; check_comb();
        check(cc_next & 8'h2F, 8'h25, "R3 R6 wrap to zero");
        acc_in = 8'h7F; opnd_in = 8'h01; cc_in = 8'h00; #1; check_comb();
        check(cc_next[1] ? 8'd1 : 8'd0, 8'd1, "R4 positive overflow");
        op_sub = 1'b1; acc_in = 8'h80; opnd_in = 8'h01; cc_in = 8'h20; #1; check_comb();
        check(cc_next & 8'h2F, 8'h22, "R5 R7 negative overflow");
        acc_in = 8'h00; opnd_in = 8'h00; cc_in = 8'h01; #1; check_comb();
        check(sum_out, 8'hFF, "R2 borrow through zero");

        // exhaustive sweep of combinational outputs
        for (int s = 0; s < 2; s++) begin
            for (int c = 0; c < 2; c++) begin
                for (int a = 0; a < 256; a++) begin
                    for (int b = 0; b < 256; b++) begin
                        op_sub  = s[0];
                        acc_in  = a[7:0];
                        opnd_in = b[7:0];
                        cc_in   = {$urandom_range(0, 255)} [7:0];
                        cc_in[0] = c[0];
                        #1;
                        check_comb();
                    end
                end
            end
        end

        // registered path: random update strobe and occasional reset
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        exp_sum = 8'h00;
        exp_cc  = 8'h00;
        for (int k = 0; k < 3000; k++) begin
            acc_in  = (k % 7 == 0) ? 8'h80 : 8'($urandom);
            opnd_in = (k % 11 == 0) ? 8'h7F : 8'($urandom);
            cc_in   = 8'($urandom);
            op_sub  = 1'($urandom);
            upd_en  = ($urandom_range(0, 2) != 0);
            rst     = ($urandom_range(0, 99) == 0);
            e = ref_model(acc_in, opnd_in, cc_in, op_sub);
            if (rst) begin
                exp_sum = 8'h00;
                exp_cc  = 8'h00;
            end else if (upd_en) begin
                exp_sum = e[15:8];
                exp_cc  = e[7:0];
            end
            @(negedge clk);
            check(sum_q, exp_sum, rst ? "R10 reset sum" : "R9 registered sum");
            check(cc_q, exp_cc, rst ? "R10 reset cc" : "R9 registered cc");
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule